// File: doc/BRIEF.md
# Calibrated Write Latency Scheduler

This block sits on the controller side of a half-rate memory PHY and times each write burst. The write command is issued through a two-slot chip-select vector. The block then counts a write latency that calibration supplies at run time and drives the write-data-valid vector and the packed write data. One memory-clock slot earlier, it raises the data-strobe burst enable. Each controller clock covers two memory-clock slots. In every 2-bit vector, bit 0 is the earlier slot and bit 1 the later one.

A request carries a full burst of 64 bits, which goes out over two controller clocks: the lower word first, then the upper word. Inside a 32-bit word, byte 0 (bits 7:0) reaches the 8-bit pins first, then bits 15:8, then 23:16, then 31:24. Pending bursts wait in order in a small store. A line of countdown tokens marks when each burst is due. This lets a new command be issued before earlier bursts have finished.

A beat sequencer reads each due token and walks through five named states. IDLE moves to LEAD when a token comes due. LEAD always moves to BEAT0. BEAT0 moves to BEAT1, or to BEAT1_LEAD when the next burst's token comes due in that cycle. BEAT1 moves to LEAD if a token comes due, and to IDLE otherwise. BEAT1_LEAD always moves to BEAT0, so back-to-back bursts follow each other with no gap.

Top module: `wls_write_sched`

## Requirements
- R1: While reset is held and just after it is released, cs_n_o is 2'b11, dqs_burst_o is 2'b00, wdata_valid_o is 2'b00 and wdata_o is zero.
- R2: An accepted request drives cs_n_o to 2'b10 (slot 0 low) for exactly one controller clock: the clock that follows the edge at which the request was sampled. At all other times cs_n_o is 2'b11.
- R3: A request sampled in the clock directly after an accepted request is ignored. It produces no chip select and no burst.
- R4: If chip select is asserted in cycle C with latency L sampled alongside the request, wdata_valid_o is 2'b11 in cycles C+L+1 and C+L+2. Outside bursts it is 2'b00.
- R5: A latency input of 0 behaves exactly like a latency of 1.
- R6: dqs_burst_o is 2'b10 (later slot only) in the cycle before a burst's first valid cycle, unless the previous burst is still running in that cycle. It is 2'b11 in every cycle in which wdata_valid_o is 2'b11.
- R7: In a burst's first valid cycle, wdata_o equals bits 31:0 of that request's wr_burst_i, and in its second valid cycle it equals bits 63:32. Byte k of each word, bits 8k+7:8k, is the k-th beat on the pins. While wdata_valid_o is 2'b00, wdata_o is zero.
- R8: Two writes whose requests are one idle clock apart produce contiguous bursts. dqs_burst_o stays 2'b11 across the seam between them.
- R9: With the latency at its maximum of 15 and requests one idle clock apart, at least nine bursts are outstanding at once. They come out in request order, each at its own latency.
- R10: When no burst is in its preamble or data cycles, dqs_burst_o and wdata_valid_o are both 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req_i | input | 1 | Write command request |
| wr_burst_i | input | 64 | Burst data; bits 31:0 go out first, then bits 63:32 |
| wr_lat_i | input | 4 | Calibrated write latency in controller clocks, sampled with the request |
| cs_n_o | output | 2 | Chip-select vector, active low, bit 0 is the earlier slot |
| dqs_burst_o | output | 2 | Strobe burst enable per slot |
| wdata_valid_o | output | 2 | Write data valid per slot |
| wdata_o | output | 32 | Packed write data, byte 0 first on the pins |

## Verification
The delicate overlap comes with spaced writes. The second burst's strobe preamble falls in the same cycle as the first burst's final data beat. The sequencer must then keep the strobe enable high and start the next burst with no gap. The bench provokes this with directed spaced-write runs and with random request streams at random calibrated latencies, including the maximum. A cycle-indexed model built from the request times predicts the strobe, valid, chip-select and data values for every cycle. Requests that land in the cycle after an acceptance are also sent deliberately, and the bench checks that they leave no chip select or burst.

// File: rtl/wls_pkg.sv
package wls_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BEAT0,
        ST_BEAT1,
        ST_BEAT1_LEAD
    } beat_state_e;
endpackage

// File: rtl/wls_token_line.sv
// Countdown line: a token inserted at position lat-1 reaches the head
// lat-1 clocks after insertion; zero latency is promoted to one.
module wls_token_line #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insert,
    input  logic [LAT_W-1:0] lat,
    output logic             due
);
    localparam int LEN = (1 << LAT_W) - 1;

    logic [LEN-1:0]   tok;
    logic [LEN:0]     tok_ext;
    logic [LAT_W-1:0] pos;

    assign pos     = (lat == '0) ? '0 : lat - 1'b1;
    assign tok_ext = {1'b0, tok};
    assign due     = tok[0];

    for (genvar i = 0; i < LEN; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tok[i] <= 1'b0;
            end else begin
                tok[i] <= tok_ext[i+1] | (insert && (pos == LAT_W'(i)));
            end
        end
    end
endmodule

// File: rtl/wls_burst_fifo.sv
// In-order store of pending bursts; DEPTH must be a power of two.
module wls_burst_fifo #(
    parameter int BURST_W = 64,
    parameter int DEPTH   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [BURST_W-1:0] push_data,
    input  logic               pop,
    output logic [BURST_W-1:0] head,
    output logic               full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [BURST_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W:0]     count;
    logic               do_pop;

    assign do_pop = pop && (count != '0);
    assign full   = (count == (PTR_W+1)'(DEPTH));
    assign head   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(do_pop);
        end
    end
endmodule

// File: rtl/wls_beat_fsm.sv
// Beat sequencer: preamble, two data cycles, chaining into the next burst.
module wls_beat_fsm
    import wls_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lead_due,
    input  logic [2*DATA_W-1:0] head,
    output logic [1:0]          dqs_burst,
    output logic [1:0]          wvalid,
    output logic [DATA_W-1:0]   wdata,
    output logic                pop
);
    beat_state_e state;
    beat_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       state_nx = lead_due ? ST_LEAD : ST_IDLE;
            ST_LEAD:       state_nx = ST_BEAT0;
            ST_BEAT0:      state_nx = lead_due ? ST_BEAT1_LEAD : ST_BEAT1;
            ST_BEAT1:      state_nx = lead_due ? ST_LEAD : ST_IDLE;
            ST_BEAT1_LEAD: state_nx = ST_BEAT0;
            default:       state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        dqs_burst = 2'b00;
        wvalid    = 2'b00;
        wdata     = '0;
        pop       = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LEAD: begin
                dqs_burst = 2'b10;
            end
            ST_BEAT0: begin
                dqs_burst = 2'b11;
                wvalid    = 2'b11;
                wdata     = head[DATA_W-1:0];
            end
            ST_BEAT1, ST_BEAT1_LEAD: begin
                dqs_burst = 2'b11;
                wvalid    = 2'b11;
                wdata     = head[2*DATA_W-1:DATA_W];
                pop       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wls_write_sched.sv
module wls_write_sched #(
    parameter int MEM_W    = 8,
    parameter int BEATS    = 4,
    parameter int LAT_W    = 4,
    parameter int DEPTH    = 16,
    localparam int DATA_W  = MEM_W * BEATS,
    localparam int BURST_W = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req_i,
    input  logic [BURST_W-1:0] wr_burst_i,
    input  logic [LAT_W-1:0]   wr_lat_i,
    output logic [1:0]         cs_n_o,
    output logic [1:0]         dqs_burst_o,
    output logic [1:0]         wdata_valid_o,
    output logic [DATA_W-1:0]  wdata_o
);
    logic               acc_q;
    logic               accept;
    logic               fifo_full;
    logic               lead_due;
    logic               pop;
    logic [BURST_W-1:0] head;

    // one idle clock is required between accepted commands
    assign accept = wr_req_i && !acc_q && !fifo_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= 1'b0;
            cs_n_o <= 2'b11;
        end else begin
            acc_q  <= accept;
            cs_n_o <= accept ? 2'b10 : 2'b11;
        end
    end

    wls_token_line #(.LAT_W(LAT_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .insert (accept),
        .lat    (wr_lat_i),
        .due    (lead_due)
    );

    wls_burst_fifo #(.BURST_W(BURST_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (wr_burst_i),
        .pop       (pop),
        .head      (head),
        .full      (fifo_full)
    );

    wls_beat_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead_due  (lead_due),
        .head      (head),
        .dqs_burst (dqs_burst_o),
        .wvalid    (wdata_valid_o),
        .wdata     (wdata_o),
        .pop       (pop)
    );
endmodule

// File: rtl/wls_write_sched_chk.sv
module wls_write_sched_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cs_n_o,
    input logic [1:0]        dqs_burst_o,
    input logic [1:0]        wdata_valid_o,
    input logic [DATA_W-1:0] wdata_o
);
    assert_cs_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o == 2'b11) || (cs_n_o == 2'b10));

    assert_no_adjacent_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o == 2'b10) |=> (cs_n_o == 2'b11));

    assert_valid_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata_valid_o == 2'b00) || (wdata_valid_o == 2'b11));

    assert_valid_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdata_valid_o[0]) |=> (wdata_valid_o == 2'b11));

    assert_lead_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdata_valid_o[0]) |-> $past(dqs_burst_o == 2'b10));

    assert_strobe_covers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata_valid_o != 2'b00) |-> (dqs_burst_o == 2'b11));

    assert_data_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata_valid_o == 2'b00) |-> (wdata_o == '0));

    assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_burst_o == 2'b00) |-> (wdata_valid_o == 2'b00));
endmodule

bind wls_write_sched wls_write_sched_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n_o        (cs_n_o),
    .dqs_burst_o   (dqs_burst_o),
    .wdata_valid_o (wdata_valid_o),
    .wdata_o       (wdata_o)
);

// File: tb/tb_wls_write_sched.sv
`timescale 1ns/1ps
module tb_wls_write_sched;
    localparam int NCYC = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req_i = 1'b0;
    logic [63:0] wr_burst_i = '0;
    logic [3:0]  wr_lat_i = '0;
    logic [1:0]  cs_n_o;
    logic [1:0]  dqs_burst_o;
    logic [1:0]  wdata_valid_o;
    logic [31:0] wdata_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    bit    last_acc = 1'b0;
    string phase = "R1 reset";

    logic [1:0]  exp_cs  [NCYC];
    logic [1:0]  exp_dqs [NCYC];
    logic [1:0]  exp_val [NCYC];
    logic [31:0] exp_dat [NCYC];

    wls_write_sched dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_req_i      (wr_req_i),
        .wr_burst_i    (wr_burst_i),
        .wr_lat_i      (wr_lat_i),
        .cs_n_o        (cs_n_o),
        .dqs_burst_o   (dqs_burst_o),
        .wdata_valid_o (wdata_valid_o),
        .wdata_o       (wdata_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff_lat(input logic [3:0] l);
        return (l == 4'd0) ? 1 : int'(l);
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            bit bad;
            bad = 1'b0;
            n_cmp++;
            if (cs_n_o !== exp_cs[cyc]) begin
                bad = 1'b1;
                $display("FAIL [%s] R2 cycle %0d cs_n actual %b expected %b", phase, cyc, cs_n_o, exp_cs[cyc]);
            end
            if (wdata_valid_o !== exp_val[cyc]) begin
                bad = 1'b1;
                $display("FAIL [%s] %s cycle %0d valid actual %b expected %b", phase,
                         (exp_val[cyc] == 2'b00) ? "R10" : "R4", cyc, wdata_valid_o, exp_val[cyc]);
            end
            if (dqs_burst_o !== exp_dqs[cyc]) begin
                bad = 1'b1;
                $display("FAIL [%s] R6 cycle %0d dqs actual %b expected %b", phase, cyc, dqs_burst_o, exp_dqs[cyc]);
            end
            if (wdata_o !== exp_dat[cyc]) begin
                bad = 1'b1;
                $display("FAIL [%s] R7 cycle %0d data actual %h expected %h", phase, cyc, wdata_o, exp_dat[cyc]);
            end
            if (bad) n_bad++;
        end
    end

    // one controller clock of stimulus, driven at the falling edge
    task automatic step(input bit req, input logic [3:0] lat);
        logic [63:0] b;
        bit acc;
        b = {$urandom, $urandom};
        wr_req_i   = req;
        wr_lat_i   = lat;
        wr_burst_i = b;
        acc = req && !last_acc;
        if (acc) begin
            int c;
            int ld;
            c  = cyc + 1;
            ld = c + eff_lat(lat);
            exp_cs[c]     = 2'b10;
            exp_dqs[ld]   = exp_dqs[ld] | 2'b10;
            exp_dqs[ld+1] = 2'b11;
            exp_dqs[ld+2] = 2'b11;
            exp_val[ld+1] = 2'b11;
            exp_val[ld+2] = 2'b11;
            exp_dat[ld+1] = b[31:0];
            exp_dat[ld+2] = b[63:32];
        end
        last_acc = acc;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [3:0] lat);
        for (int i = 0; i < n; i++) step(1'b0, lat);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCYC; i++) begin
            exp_cs[i]  = 2'b11;
            exp_dqs[i] = 2'b00;
            exp_val[i] = 2'b00;
            exp_dat[i] = '0;
        end
        wr_req_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle outputs while reset held, even with a request present
        n_cmp++;
        if (cs_n_o !== 2'b11 || dqs_burst_o !== 2'b00 || wdata_valid_o !== 2'b00 || wdata_o !== '0) begin
            n_bad++;
            $display("FAIL R1 reset outputs actual %b %b %b %h expected 11 00 00 0",
                     cs_n_o, dqs_burst_o, wdata_valid_o, wdata_o);
        end
        wr_req_i = 1'b0;
        rst_n = 1'b1;
        chk_on = 1'b1;
        idle(3, 4'd2);

        phase = "R2 R4 R7 single L2";
        step(1'b1, 4'd2);
        idle(8, 4'd2);

        phase = "R3 adjacent request ignored";
        step(1'b1, 4'd3);
        step(1'b1, 4'd3);
        idle(10, 4'd3);

        phase = "R5 zero latency";
        step(1'b1, 4'd0);
        idle(6, 4'd0);
        step(1'b1, 4'd1);
        idle(6, 4'd1);

        phase = "R8 spaced writes";
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 4'd4);
            step(1'b0, 4'd4);
        end
        idle(12, 4'd4);

        phase = "R6 gap of two";
        step(1'b1, 4'd5);
        idle(2, 4'd5);
        step(1'b1, 4'd5);
        idle(12, 4'd5);

        phase = "R9 max latency outstanding";
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 4'd15);
            step(1'b0, 4'd15);
        end
        idle(25, 4'd15);

        phase = "random R4 R7 R8";
        for (int s = 0; s < 8; s++) begin
            logic [3:0] l;
            int dens;
            l = 4'($urandom_range(0, 15));
            dens = $urandom_range(1, 3);
            for (int i = 0; i < 200; i++) begin
                step(($urandom_range(0, 3) < dens), l);
            end
            idle(25, l);
        end

        chk_on = 1'b0;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        summary();
        $finish;
    end
endmodule